// File: doc/BRIEF.md
# Sa6 Spare-Bit Code Detector

This block sits behind an E1 receive framer. It watches the stream of Sa6 spare bits that the framer has pulled out of time slot 0. Each bit arrives on its own clock cycle, qualified by a valid strobe. With the bit come two alignment flags and a marker that tags the last Sa6 bit of a CRC-4 submultiframe. The block cuts the stream into 4-bit groups, with the earliest bit as the most significant. It looks for five spare-bit code patterns and raises one alarm output per pattern. An alarm rises once its pattern has repeated over three groups in a row. It falls once three groups in a row have carried something else.

Grouping has two forms, chosen by a mode input. In free-running mode the detector hunts with a 4-bit window that slides on every bit. After a hit it locks onto the bit phase of that hit and evaluates every fourth bit. In submultiframe mode a group is exactly the four bits that end at a boundary marker. Free-running mode needs basic frame alignment only. Submultiframe mode also needs CRC-4 multiframe alignment. Losing the required alignment, or switching mode, throws away all history and clears the alarms.

Top module: `sa6_code_detector`

## Requirements
- R1: Recognised codes, first bit received as the MSB, map onto alarm bits as follows: 1000 to bit 0, 1010 to bit 1, 1100 to bit 2, 1110 to bit 3, 1111 to bit 4.
- R2: In free-running mode an alarm sets when the 12 most recent valid bits hold the same recognised 4-bit group three times over. This works at any bit phase of the stream.
- R3: An active alarm clears when three consecutive groups all differ from its code. The three groups may differ from each other and may be unrecognised.
- R4: Three consecutive groups of another recognised code replace the active alarm in the same evaluation, with no all-zero cycle between.
- R5: A group outside the five codes never sets an alarm.
- R6: While an alarm is active in free-running mode, groups are evaluated only on every fourth valid bit, counted from the evaluation that set the alarm.
- R7: In submultiframe mode a group is the four valid bits ending with the boundary-marked bit. A boundary that ends any other number of bits discards that group and restarts the three-group count.
- R8: Free-running mode runs while basic frame alignment is held. Submultiframe mode runs only while both basic frame alignment and CRC-4 multiframe alignment are held.
- R9: Loss of the required alignment, a change of mode, or reset clears all alarms and all group history. A later detection again needs three complete new groups.
- R10: At most one alarm output is high at any time.
- R11: Cycles without the valid strobe leave the alarms and the grouping unchanged, whatever the bit and boundary inputs carry.
- R12: An alarm change appears on the output in the cycle after the clock edge that takes the bit completing the deciding group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 selects submultiframe-locked grouping, 0 selects free-running grouping |
| bfa_ok_i | input | 1 | Basic frame alignment held |
| mfa_ok_i | input | 1 | CRC-4 multiframe alignment held |
| bit_valid_i | input | 1 | Qualifies bit_i and smf_end_i for this cycle |
| bit_i | input | 1 | Received Sa6 bit |
| smf_end_i | input | 1 | This valid bit is the last Sa6 bit of a submultiframe |
| code_alarm_o | output | 5 | One alarm per recognised code, bit order as in R1 |

## Verification
The assertions take it that the boundary marker only means something together with the valid strobe. They also take the mode and alignment inputs to be static levels: a change in either is treated as a restart, never as a glitch to be filtered. The stimulus drives all configuration changes between bits and keeps the valid strobe low on those cycles. It does drive the boundary marker and a toggling bit value during idle gaps, to show that unqualified inputs are ignored. Every valid bit is followed by a comparison against a bench model that works on queues of bits and groups. Sweeps cover all 16 patterns at every bit phase in free-running mode and all 16 patterns in submultiframe mode.

// File: rtl/sa6_pkg.sv
package sa6_pkg;
   localparam int CODE_W  = 4;
   localparam int N_CODES = 5;

   // Alarm bit k belongs to SA6_CODES[k]; MSB is the first bit received.
   localparam logic [CODE_W-1:0] SA6_CODES [N_CODES] = '{
      4'b1000, 4'b1010, 4'b1100, 4'b1110, 4'b1111
   };
endpackage

// File: rtl/sa6_code_match.sv
module sa6_code_match
   import sa6_pkg::*;
#(
   parameter int GRP_W     = CODE_W,
   parameter int NUM_CODES = N_CODES
) (
   input  logic [GRP_W-1:0]     nib,
   output logic [NUM_CODES-1:0] hit
);
   if (GRP_W != CODE_W) begin : g_bad_width
      $error("sa6_code_match: GRP_W must equal the code width");
   end
   if (NUM_CODES > N_CODES) begin : g_bad_count
      $error("sa6_code_match: NUM_CODES exceeds the code table");
   end

   for (genvar k = 0; k < NUM_CODES; k++) begin : g_cmp
      assign hit[k] = (nib == SA6_CODES[k]);
   end
endmodule

// File: rtl/sa6_grouper.sv
module sa6_grouper #(
   parameter int GRP_W    = 4,
   parameter int RUN_LEN  = 3,
   parameter bit HAS_SYNC = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     sync_mode,
   input  logic                     bit_valid,
   input  logic                     bit_in,
   input  logic                     smf_end,
   input  logic                     lock,
   output logic                     eval_stb,
   output logic [RUN_LEN*GRP_W-1:0] hist_o
);
   localparam int HW  = RUN_LEN * GRP_W;
   localparam int AFW = $clog2(HW + 1);
   localparam int PHW = (GRP_W > 2) ? $clog2(GRP_W) : 1;
   localparam int BCW = $clog2(GRP_W + 1);
   localparam int GFW = $clog2(RUN_LEN + 1);
   localparam logic [AFW-1:0] A_FULL  = AFW'(HW);
   localparam logic [AFW-1:0] A_READY = AFW'(HW - 1);
   localparam logic [PHW-1:0] PH_LAST = PHW'(GRP_W - 1);

   if (GRP_W < 2) begin : g_bad_grp
      $error("sa6_grouper: GRP_W must be at least 2");
   end
   if (RUN_LEN < 2) begin : g_bad_run
      $error("sa6_grouper: RUN_LEN must be at least 2");
   end

   // ---------------- free-running path: sliding bit window ----------------
   logic [HW-1:0]  a_hist;
   logic [HW-1:0]  a_next;
   logic [AFW-1:0] a_fill;
   logic [PHW-1:0] a_ph;
   logic           a_take;
   logic           a_ready;
   logic           a_stb;

   assign a_take  = bit_valid && !(HAS_SYNC && sync_mode);
   assign a_next  = {a_hist[HW-2:0], bit_in};
   assign a_ready = (a_fill >= A_READY);
   // Hunting: every bit. Locked: once per group, on the phase of the hit.
   assign a_stb   = a_take && a_ready && (!lock || (a_ph == PH_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_hist <= '0;
         a_fill <= '0;
         a_ph   <= '0;
      end else if (flush) begin
         a_hist <= '0;
         a_fill <= '0;
         a_ph   <= '0;
      end else if (a_take) begin
         a_hist <= a_next;
         if (a_fill != A_FULL) begin
            a_fill <= a_fill + 1'b1;
         end
         if (a_stb || (a_ph == PH_LAST)) begin
            a_ph <= '0;
         end else begin
            a_ph <= a_ph + 1'b1;
         end
      end
   end

   // ---------------- submultiframe path: boundary-locked groups -----------
   logic          s_stb;
   logic [HW-1:0] s_view;

   if (HAS_SYNC) begin : g_sync
      localparam logic [BCW-1:0] B_FULL  = BCW'(GRP_W);
      localparam logic [BCW-1:0] B_LAST  = BCW'(GRP_W - 1);
      localparam logic [GFW-1:0] G_FULL  = GFW'(RUN_LEN);
      localparam logic [GFW-1:0] G_READY = GFW'(RUN_LEN - 1);

      logic [GRP_W-1:0] s_nib;
      logic [GRP_W-1:0] s_nib_next;
      logic [BCW-1:0]   s_cnt;
      logic [HW-1:0]    s_hist;
      logic [HW-1:0]    s_hist_next;
      logic [GFW-1:0]   s_fill;
      logic             s_take;
      logic             s_full;
      logic             s_cap;

      assign s_take      = bit_valid && sync_mode;
      assign s_nib_next  = {s_nib[GRP_W-2:0], bit_in};
      assign s_full      = (s_cnt == B_LAST);
      assign s_cap       = s_take && smf_end && s_full;
      assign s_hist_next = {s_hist[HW-GRP_W-1:0], s_nib_next};
      assign s_stb       = s_cap && (s_fill >= G_READY);
      assign s_view      = s_hist_next;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_nib  <= '0;
            s_cnt  <= '0;
            s_hist <= '0;
            s_fill <= '0;
         end else if (flush) begin
            s_nib  <= '0;
            s_cnt  <= '0;
            s_hist <= '0;
            s_fill <= '0;
         end else if (s_take) begin
            s_nib <= s_nib_next;
            if (smf_end) begin
               s_cnt <= '0;
               if (s_full) begin
                  s_hist <= s_hist_next;
                  if (s_fill != G_FULL) begin
                     s_fill <= s_fill + 1'b1;
                  end
               end else begin
                  // Short or long submultiframe: the run is broken.
                  s_fill <= '0;
               end
            end else if (s_cnt != B_FULL) begin
               s_cnt <= s_cnt + 1'b1;
            end
         end
      end
   end else begin : g_async_only
      assign s_stb  = 1'b0;
      assign s_view = '0;
   end

   assign eval_stb = a_stb | s_stb;
   assign hist_o   = (HAS_SYNC && sync_mode) ? s_view : a_next;
endmodule

// File: rtl/sa6_persist.sv
module sa6_persist
   import sa6_pkg::*;
#(
   parameter int GRP_W     = CODE_W,
   parameter int RUN_LEN   = 3,
   parameter int NUM_CODES = N_CODES
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     eval_stb,
   input  logic [RUN_LEN*GRP_W-1:0] hist,
   output logic [NUM_CODES-1:0]     alarm,
   output logic                     active
);
   // grp[0] is the newest group, grp[RUN_LEN-1] the oldest.
   logic [GRP_W-1:0]     grp [RUN_LEN];
   logic [RUN_LEN-1:0]   same_v;
   logic [RUN_LEN-1:0]   diff_v;
   logic [NUM_CODES-1:0] hit;
   logic [GRP_W-1:0]     act_code;
   logic                 all_same;
   logic                 all_diff;
   logic                 take;
   logic                 drop;

   for (genvar i = 0; i < RUN_LEN; i++) begin : g_slice
      assign grp[i]    = hist[i*GRP_W +: GRP_W];
      assign same_v[i] = (grp[i] == grp[0]);
      assign diff_v[i] = (grp[i] != act_code);
   end

   sa6_code_match #(
      .GRP_W     (GRP_W),
      .NUM_CODES (NUM_CODES)
   ) u_match (
      .nib (grp[0]),
      .hit (hit)
   );

   assign active   = |alarm;
   assign all_same = &same_v;
   assign all_diff = active && (&diff_v);
   assign take     = eval_stb && (!active || all_diff) && all_same && (|hit);
   assign drop     = eval_stb && all_diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm    <= '0;
         act_code <= '0;
      end else if (flush) begin
         alarm    <= '0;
         act_code <= '0;
      end else if (take) begin
         alarm    <= hit;
         act_code <= grp[0];
      end else if (drop) begin
         alarm    <= '0;
      end
   end
endmodule

// File: rtl/sa6_code_detector.sv
module sa6_code_detector
   import sa6_pkg::*;
#(
   parameter int GRP_W     = CODE_W,
   parameter int RUN_LEN   = 3,
   parameter int NUM_CODES = N_CODES,
   parameter bit HAS_SYNC  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sync_mode_i,
   input  logic                 bfa_ok_i,
   input  logic                 mfa_ok_i,
   input  logic                 bit_valid_i,
   input  logic                 bit_i,
   input  logic                 smf_end_i,
   output logic [NUM_CODES-1:0] code_alarm_o
);
   localparam int HW = RUN_LEN * GRP_W;

   if (GRP_W != CODE_W) begin : g_bad_width
      $error("sa6_code_detector: GRP_W must equal the code width");
   end
   if (RUN_LEN < 2) begin : g_bad_run
      $error("sa6_code_detector: RUN_LEN must be at least 2");
   end

   logic          mode_q;
   logic          align_ok;
   logic          flush;
   logic          eval_stb;
   logic          lock;
   logic [HW-1:0] hist;

   assign align_ok = (HAS_SYNC && sync_mode_i) ? (bfa_ok_i && mfa_ok_i) : bfa_ok_i;
   assign flush    = !align_ok || (sync_mode_i != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else begin
         mode_q <= sync_mode_i;
      end
   end

   sa6_grouper #(
      .GRP_W    (GRP_W),
      .RUN_LEN  (RUN_LEN),
      .HAS_SYNC (HAS_SYNC)
   ) u_group (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .sync_mode (sync_mode_i),
      .bit_valid (bit_valid_i),
      .bit_in    (bit_i),
      .smf_end   (smf_end_i),
      .lock      (lock),
      .eval_stb  (eval_stb),
      .hist_o    (hist)
   );

   sa6_persist #(
      .GRP_W     (GRP_W),
      .RUN_LEN   (RUN_LEN),
      .NUM_CODES (NUM_CODES)
   ) u_persist (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .eval_stb (eval_stb),
      .hist     (hist),
      .alarm    (code_alarm_o),
      .active   (lock)
   );
endmodule

// File: rtl/sa6_code_detector_chk.sv
module sa6_code_detector_chk #(
   parameter int NUM_CODES = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sync_mode_i,
   input logic                 bit_valid_i,
   input logic                 smf_end_i,
   input logic                 flush,
   input logic                 eval_stb,
   input logic [NUM_CODES-1:0] code_alarm_o
);
   assert_alarm_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(code_alarm_o));

   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (code_alarm_o == '0));

   assert_sync_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_stb && sync_mode_i) |-> (bit_valid_i && smf_end_i));

   assert_change_after_eval_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (code_alarm_o != $past(code_alarm_o)) |-> ($past(eval_stb) || $past(flush)));

   assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid_i && !flush) |=> $stable(code_alarm_o));
endmodule

bind sa6_code_detector sa6_code_detector_chk #(.NUM_CODES(NUM_CODES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sync_mode_i  (sync_mode_i),
   .bit_valid_i  (bit_valid_i),
   .smf_end_i    (smf_end_i),
   .flush        (flush),
   .eval_stb     (eval_stb),
   .code_alarm_o (code_alarm_o)
);

// File: tb/sa6_code_detector_test.sv
module sa6_code_detector_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_mode = 1'b0;
   logic       bfa = 1'b0;
   logic       mfa = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic       smf_end = 1'b0;
   logic [4:0] alarm;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sa6_code_detector uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_mode_i  (sync_mode),
      .bfa_ok_i     (bfa),
      .mfa_ok_i     (mfa),
      .bit_valid_i  (bit_valid),
      .bit_i        (bit_in),
      .smf_end_i    (smf_end),
      .code_alarm_o (alarm)
   );

   // ---------------- requirement-level helpers ----------------
   function automatic bit is_code(int n);
      return (n == 8) || (n == 10) || (n == 12) || (n == 14) || (n == 15);
   endfunction

   function automatic logic [4:0] bit_of(int n);   // R1 mapping
      case (n)
         8:       return 5'b00001;
         10:      return 5'b00010;
         12:      return 5'b00100;
         14:      return 5'b01000;
         15:      return 5'b10000;
         default: return 5'b00000;
      endcase
   endfunction

   function automatic logic [4:0] rot_alarm(int p);
      for (int r = 0; r < 4; r++) begin
         int q = ((p << r) | (p >> (4 - r))) & 15;
         if (is_code(q)) return bit_of(q);
      end
      return 5'b00000;
   endfunction

   // ---------------- bench model built from queues ----------------
   int   m_act = -1;
   bit   mq[$];
   int   gq[$];
   int   m_nib = 0;
   int   m_cnt = 0;
   int   m_since = 0;
   bit   m_mode = 1'b0;
   bit   m_align = 1'b0;

   task automatic m_flush();
      mq.delete();
      gq.delete();
      m_nib = 0; m_cnt = 0; m_since = 0; m_act = -1;
   endtask

   function automatic logic [4:0] m_exp();
      return (m_act < 0) ? 5'b00000 : bit_of(m_act);
   endfunction

   task automatic m_eval(int old_g, int mid_g, int new_g);
      bit same = (old_g == mid_g) && (mid_g == new_g);
      bit diff = (m_act >= 0) && (old_g != m_act) && (mid_g != m_act) && (new_g != m_act);
      if ((m_act < 0 || diff) && same && is_code(new_g)) m_act = new_g;
      else if (diff) m_act = -1;
   endtask

   task automatic m_bit(bit b, bit smf);
      if (!m_align) return;
      if (!m_mode) begin
         mq.push_back(b);
         if (mq.size() > 12) void'(mq.pop_front());
         m_since++;
         if (mq.size() == 12 && (m_act < 0 || m_since == 4)) begin
            int g[3];
            for (int k = 0; k < 3; k++)
               g[k] = mq[4*k]*8 + mq[4*k+1]*4 + mq[4*k+2]*2 + mq[4*k+3];
            m_eval(g[0], g[1], g[2]);
            m_since = 0;
         end
      end else begin
         m_nib = ((m_nib << 1) | b) & 15;
         if (smf) begin
            if (m_cnt == 3) begin
               gq.push_back(m_nib);
               if (gq.size() > 3) void'(gq.pop_front());
               if (gq.size() == 3) m_eval(gq[0], gq[1], gq[2]);
            end else begin
               gq.delete();
            end
            m_cnt = 0;
         end else if (m_cnt < 4) begin
            m_cnt++;
         end
      end
   endtask

   // ---------------- drivers and checks ----------------
   task automatic chk(string tag, logic [4:0] got, logic [4:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: alarm=%b expected %b", tag, got, exp);
      end
   endtask

   task automatic put(bit b, bit smf, string tag);
      bit_valid = 1'b1; bit_in = b; smf_end = smf;
      @(posedge clk);
      m_bit(b, smf);
      @(negedge clk);
      bit_valid = 1'b0; smf_end = 1'b0;
      chk(tag, alarm, m_exp());
   endtask

   task automatic put_nib(logic [3:0] n, bit smf_grp, string tag);
      for (int i = 3; i >= 0; i--) put(n[i], smf_grp && (i == 0), tag);
   endtask

   task automatic cfg(bit mode, bit b_ok, bit m_ok);
      bit new_align = mode ? (b_ok && m_ok) : b_ok;
      sync_mode = mode; bfa = b_ok; mfa = m_ok;
      @(posedge clk);
      if (!new_align || mode != m_mode) m_flush();
      m_mode = mode; m_align = new_align;
      @(negedge clk);
      chk("R9 configuration step", alarm, m_exp());
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         bit_valid = 1'b0; bit_in = i[0]; smf_end = 1'b1;
         @(negedge clk);
         chk("R11 idle cycle", alarm, m_exp());
      end
      smf_end = 1'b0;
   endtask

   // ---------------- stimulus ----------------
   initial begin
      repeat (4) @(negedge clk);
      chk("R9 during reset", alarm, 5'b00000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after reset", alarm, 5'b00000);

      // R1/R2/R5: all patterns at all bit phases, free-running mode
      for (int p = 0; p < 16; p++) begin
         for (int off = 0; off < 4; off++) begin
            cfg(1'b0, 1'b0, 1'b0);
            cfg(1'b0, 1'b1, 1'b0);
            for (int k = 0; k < off; k++) put(1'b0, 1'b0, "R2 lead-in");
            for (int rep = 0; rep < 4; rep++) put_nib(4'(p), 1'b0, "R2 sweep");
            chk($sformatf("R1 R2 R5 pattern %0d phase %0d", p, off), alarm, rot_alarm(p));
         end
      end

      // R7/R1/R5: all patterns, submultiframe mode
      for (int p = 0; p < 16; p++) begin
         cfg(1'b1, 1'b0, 1'b1);
         cfg(1'b1, 1'b1, 1'b1);
         for (int rep = 0; rep < 4; rep++) put_nib(4'(p), 1'b1, "R7 sweep");
         chk($sformatf("R7 R5 sync pattern %0d", p), alarm,
             is_code(p) ? bit_of(p) : 5'b00000);
      end

      // R12: exact cycle of assertion
      cfg(1'b1, 1'b0, 1'b1);
      cfg(1'b1, 1'b1, 1'b1);
      put_nib(4'hE, 1'b1, "R12 setup");
      put_nib(4'hE, 1'b1, "R12 setup");
      put(1'b1, 1'b0, "R12"); put(1'b1, 1'b0, "R12"); put(1'b1, 1'b0, "R12");
      chk("R12 before last bit", alarm, 5'b00000);
      put(1'b0, 1'b1, "R12");
      chk("R12 after last bit", alarm, 5'b01000);

      // R7: misaligned boundary restarts the run
      cfg(1'b1, 1'b0, 1'b1);
      cfg(1'b1, 1'b1, 1'b1);
      put_nib(4'h8, 1'b1, "R7 setup");
      put_nib(4'h8, 1'b1, "R7 setup");
      put(1'b1, 1'b0, "R7"); put(1'b0, 1'b0, "R7"); put(1'b0, 1'b1, "R7 short smf");
      put_nib(4'h8, 1'b1, "R7");
      put_nib(4'h8, 1'b1, "R7");
      chk("R7 run restarted", alarm, 5'b00000);
      put_nib(4'h8, 1'b1, "R7");
      chk("R7 third group after restart", alarm, 5'b00001);

      // R8: submultiframe mode needs multiframe alignment
      cfg(1'b1, 1'b1, 1'b0);
      for (int rep = 0; rep < 4; rep++) put_nib(4'hF, 1'b1, "R8");
      chk("R8 no multiframe alignment", alarm, 5'b00000);
      cfg(1'b0, 1'b0, 1'b1);
      for (int rep = 0; rep < 4; rep++) put_nib(4'hF, 1'b0, "R8");
      chk("R8 no basic alignment", alarm, 5'b00000);

      // R3: clear by three unrecognised, mutually different groups
      cfg(1'b0, 1'b1, 1'b0);
      for (int rep = 0; rep < 3; rep++) put_nib(4'hF, 1'b0, "R3 setup");
      chk("R3 set", alarm, 5'b10000);
      put_nib(4'h0, 1'b0, "R3"); put_nib(4'h3, 1'b0, "R3");
      chk("R3 two differing groups", alarm, 5'b10000);
      put_nib(4'h5, 1'b0, "R3");
      chk("R3 third differing group", alarm, 5'b00000);

      // R4: direct switch between codes
      cfg(1'b0, 1'b0, 1'b0);
      cfg(1'b0, 1'b1, 1'b0);
      for (int rep = 0; rep < 3; rep++) put_nib(4'hC, 1'b0, "R4 setup");
      put_nib(4'hE, 1'b0, "R4"); put_nib(4'hE, 1'b0, "R4");
      put(1'b1, 1'b0, "R4"); put(1'b1, 1'b0, "R4"); put(1'b1, 1'b0, "R4");
      chk("R4 still old code", alarm, 5'b00100);
      put(1'b0, 1'b0, "R4");
      chk("R4 switched", alarm, 5'b01000);

      // R6: phase lock keeps an alternating pattern alarm alive
      cfg(1'b0, 1'b0, 1'b0);
      cfg(1'b0, 1'b1, 1'b0);
      for (int rep = 0; rep < 3; rep++) put_nib(4'hA, 1'b0, "R6 setup");
      for (int k = 0; k < 7; k++) begin
         put(k[0] ? 1'b0 : 1'b1, 1'b0, "R6");
         chk("R6 off-phase bits ignored", alarm, 5'b00010);
      end

      // R11: idle gaps do not disturb grouping
      cfg(1'b0, 1'b0, 1'b0);
      cfg(1'b0, 1'b1, 1'b0);
      put_nib(4'h8, 1'b0, "R11"); idle(3);
      put_nib(4'h8, 1'b0, "R11"); idle(2);
      put(1'b1, 1'b0, "R11"); idle(1); put(1'b0, 1'b0, "R11");
      put(1'b0, 1'b0, "R11"); idle(2);
      chk("R11 before last bit", alarm, 5'b00000);
      put(1'b0, 1'b0, "R11");
      chk("R11 gaps transparent", alarm, 5'b00001);
      idle(4);
      chk("R11 alarm held across gap", alarm, 5'b00001);

      // R9: alignment loss and mode change clear everything
      cfg(1'b0, 1'b0, 1'b0);
      chk("R9 alignment lost", alarm, 5'b00000);
      cfg(1'b0, 1'b1, 1'b0);
      put_nib(4'hF, 1'b0, "R9"); put_nib(4'hF, 1'b0, "R9");
      chk("R9 history cleared", alarm, 5'b00000);
      put_nib(4'hF, 1'b0, "R9");
      chk("R9 re-detect", alarm, 5'b10000);
      cfg(1'b1, 1'b1, 1'b1);
      chk("R9 mode change clears", alarm, 5'b00000);
      put_nib(4'hF, 1'b1, "R9"); put_nib(4'hF, 1'b1, "R9");
      chk("R9 new mode needs three groups", alarm, 5'b00000);
      put_nib(4'hF, 1'b1, "R9");
      chk("R9 new mode detect", alarm, 5'b10000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule